// File: doc/BRIEF.md
# Pattern Playback Line Formatter

This block replays a bit pattern held in on-chip storage and turns each bit into one of three line codes: non-return-to-zero, return-to-zero and return-to-one. A host fills the storage one 32-bit word at a time while playback is halted. A length setting tells the block how many bits make up the pattern; after the last of them, playback continues from bit 0. A second data source, a built-in pseudo-random generator offering four polynomials, can replace the stored pattern.

Every bit period is emitted as a pair of half-bit samples for a double-rate serializer that follows the block. The earlier half is on bit 1 and the later half on bit 0. A one-period marker flags the start of the pattern so that downstream trigger logic can lock to it. In pseudo-random mode the marker flags the generator's seed state. Level, edge timing and crossover control sit outside this block.

Top module: `patfmt_top`

## Requirements
- R1: A write with `wr_en` high while `run` is low stores `wr_data` into word `wr_word`. Pattern bit a lives in word a/32 at bit position a%32. A write presented while `run` is high is dropped and leaves the stored pattern unchanged.
- R2: While `run` is high the block emits stored bits 0,1,…,L−1 in order and then starts again from bit 0. L is the length sampled on every clock edge at which `run` is low; changing `pat_len` while `run` is high has no effect.
- R3: With `fmt_sel` = 0 (NRZ), both halves of `half_pair` carry the bit value.
- R4: With `fmt_sel` = 1 (return-to-zero), `half_pair[1]` carries the bit and `half_pair[0]` is 0.
- R5: With `fmt_sel` = 2 (return-to-one), `half_pair[1]` carries the bit and `half_pair[0]` is 1.
- R6: `fmt_sel` = 3 is treated exactly like code 0 (NRZ).
- R7: After the first clock edge with `run` high, the outputs carry pattern bit 0. After any clock edge with `run` low, `half_pair` is 00 and `pat_start` is 0. `fmt_sel` acts on the bit registered at that edge.
- R8: With the stored-pattern source, `pat_start` is 1 during exactly those bit periods that output pattern bit 0, including every wrap. With L = 1 it stays high.
- R9: When `src_prbs` is 1, the data come from a shift register of N bits that is loaded with all ones while stopped. It outputs bit N−1 and shifts in (bit N−1 XOR bit T−1) each period. `prbs_sel` 0/1/2/3 selects (N,T) = (7,6), (15,14), (23,18), (31,28). `src_prbs` and `prbs_sel` are sampled while `run` is low.
- R10: In pseudo-random mode, `pat_start` is 1 in the bit periods in which the generator's low N bits are all ones. For N = 7 this repeats every 127 periods.
- R11: While `rst_n` is low, `half_pair` is 00 and `pat_start` is 0.
- R12: A `pat_len` of 0 is taken as 1, and any value above 8192 is taken as 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_word | input | 8 | Host word address |
| wr_data | input | 32 | Host write data |
| run | input | 1 | Playback enable; low = stopped |
| pat_len | input | 14 | Pattern length in bits |
| fmt_sel | input | 2 | Line code: 0 NRZ, 1 RZ, 2 R1, 3 NRZ |
| src_prbs | input | 1 | 1 selects the pseudo-random source |
| prbs_sel | input | 2 | Polynomial select |
| half_pair | output | 2 | Half-bit pair, first half in bit 1 |
| pat_start | output | 1 | Pattern start marker |

## Verification
A host write and a length change can arrive in the same cycle as active playback. The bench provokes this by presenting a word write to address 0 and a new length midway through a run. It judges the result twice. First, the running sequence must keep its old wrap point. Second, once the block is stopped, a replay must show the original contents of word 0. The wrap and the start marker also fall on the same cycle in every period. A one-bit length makes them coincide on every cycle, and the bench checks the marker in each case.

// File: rtl/patfmt_pkg.sv
package patfmt_pkg;

  typedef enum logic [1:0] {
    FMT_NRZ   = 2'd0,
    FMT_RZ    = 2'd1,
    FMT_RONE  = 2'd2,
    FMT_NRZ_B = 2'd3
  } line_fmt_e;

  localparam int PN_MAX      = 31;
  localparam int PN_VARIANTS = 4;

  // register length for each polynomial choice
  function automatic int pn_order(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // secondary feedback tap for each polynomial choice
  function automatic int pn_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/patfmt_mem.sv
module patfmt_mem #(
  parameter int MEM_BITS = 8192,
  parameter int WORD_W   = 32,
  localparam int DEPTH   = MEM_BITS / WORD_W,
  localparam int ADDR_W  = $clog2(MEM_BITS),
  localparam int BSEL_W  = $clog2(WORD_W),
  localparam int WADDR_W = ADDR_W - BSEL_W
) (
  input  logic               clk,
  input  logic               wr_go,
  input  logic [WADDR_W-1:0] wr_word,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_bit
);

  logic [WORD_W-1:0]  store_q [DEPTH];
  logic [WADDR_W-1:0] rd_word;
  logic [BSEL_W-1:0]  rd_sel;
  logic [WORD_W-1:0]  rd_data;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      store_q[wr_word] <= wr_data;
    end
  end

  assign rd_word = rd_addr[ADDR_W-1:BSEL_W];
  assign rd_sel  = rd_addr[BSEL_W-1:0];
  assign rd_data = store_q[rd_word];
  assign rd_bit  = rd_data[rd_sel];

endmodule

// File: rtl/patfmt_seq.sv
module patfmt_seq #(
  parameter int MEM_BITS = 8192,
  localparam int ADDR_W  = $clog2(MEM_BITS),
  localparam int LEN_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LEN_W-1:0]  len_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic              first_o
);

  logic [LEN_W-1:0]  len_q, len_d, len_clamped;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              len_en;
  logic              last_w;

  always_comb begin
    if (len_in == '0) begin
      len_clamped = LEN_W'(1);
    end else if (len_in > LEN_W'(MEM_BITS)) begin
      len_clamped = LEN_W'(MEM_BITS);
    end else begin
      len_clamped = len_in;
    end
  end

  assign len_en = ~run;
  assign last_w = ({1'b0, addr_q} == (len_q - LEN_W'(1)));

  always_comb begin
    len_d  = len_q;
    addr_d = addr_q;
    if (len_en) begin
      len_d = len_clamped;
    end
    if (!run) begin
      addr_d = '0;
    end else if (last_w) begin
      addr_d = '0;
    end else begin
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(1);
      addr_q <= '0;
    end else begin
      len_q  <= len_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o  = addr_q;
  assign first_o = (addr_q == '0);

endmodule

// File: rtl/patfmt_pn.sv
module patfmt_pn
  import patfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       bit_o,
  output logic       seed_o
);

  logic [PN_MAX-1:0]      st_q, st_d;
  logic [1:0]             sel_q, sel_d;
  logic [PN_VARIANTS-1:0] fb_c, out_c, seed_c;

  for (genvar g = 0; g < PN_VARIANTS; g++) begin : g_poly
    localparam int ORD = pn_order(g);
    localparam int TAP = pn_tap(g);
    assign fb_c[g]   = st_q[ORD-1] ^ st_q[TAP-1];
    assign out_c[g]  = st_q[ORD-1];
    assign seed_c[g] = &st_q[ORD-1:0];
  end

  always_comb begin
    sel_d = sel_q;
    st_d  = st_q;
    if (!run) begin
      sel_d = sel;
      st_d  = '1;
    end else begin
      st_d = {st_q[PN_MAX-2:0], fb_c[sel_q]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      st_q  <= '1;
    end else begin
      sel_q <= sel_d;
      st_q  <= st_d;
    end
  end

  assign bit_o  = out_c[sel_q];
  assign seed_o = seed_c[sel_q];

endmodule

// File: rtl/patfmt_shape.sv
module patfmt_shape
  import patfmt_pkg::*;
(
  input  logic       bit_i,
  input  line_fmt_e  fmt_i,
  output logic [1:0] pair_o
);

  always_comb begin
    unique case (fmt_i)
      FMT_RZ:   pair_o = {bit_i, 1'b0};
      FMT_RONE: pair_o = {bit_i, 1'b1};
      FMT_NRZ,
      FMT_NRZ_B: pair_o = {bit_i, bit_i};
      default:  pair_o = {bit_i, bit_i};
    endcase
  end

endmodule

// File: rtl/patfmt_top.sv
module patfmt_top
  import patfmt_pkg::*;
#(
  parameter int MEM_BITS = 8192,
  parameter int WORD_W   = 32,
  localparam int ADDR_W  = $clog2(MEM_BITS),
  localparam int LEN_W   = ADDR_W + 1,
  localparam int WADDR_W = ADDR_W - $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_word,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               run,
  input  logic [LEN_W-1:0]   pat_len,
  input  logic [1:0]         fmt_sel,
  input  logic               src_prbs,
  input  logic [1:0]         prbs_sel,
  output logic [1:0]         half_pair,
  output logic               pat_start
);

  logic              wr_go;
  logic [ADDR_W-1:0] rd_addr;
  logic              first_w, mem_bit, pn_bit, pn_seed, data_bit;
  logic              src_q, src_d, start_q, start_d;
  logic [1:0]        shaped, pair_q, pair_d;
  line_fmt_e         fmt_w;

  assign wr_go = wr_en & ~run;
  assign fmt_w = line_fmt_e'(fmt_sel);

  patfmt_seq #(.MEM_BITS(MEM_BITS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .len_in  (pat_len),
    .addr_o  (rd_addr),
    .first_o (first_w)
  );

  patfmt_mem #(.MEM_BITS(MEM_BITS), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .wr_go   (wr_go),
    .wr_word (wr_word),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_bit  (mem_bit)
  );

  patfmt_pn u_pn (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sel    (prbs_sel),
    .bit_o  (pn_bit),
    .seed_o (pn_seed)
  );

  assign data_bit = src_q ? pn_bit : mem_bit;

  patfmt_shape u_shape (
    .bit_i  (data_bit),
    .fmt_i  (fmt_w),
    .pair_o (shaped)
  );

  always_comb begin
    src_d   = src_q;
    pair_d  = 2'b00;
    start_d = 1'b0;
    if (!run) begin
      src_d = src_prbs;
    end else begin
      pair_d  = shaped;
      start_d = src_q ? pn_seed : first_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      pair_q  <= 2'b00;
      start_q <= 1'b0;
    end else begin
      src_q   <= src_d;
      pair_q  <= pair_d;
      start_q <= start_d;
    end
  end

  assign half_pair = pair_q;
  assign pat_start = start_q;

endmodule

// File: rtl/patfmt_chk.sv
module patfmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] fmt_sel,
  input logic [1:0] half_pair,
  input logic       pat_start
);

  // R3
  nrz_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt_sel == 2'd0) |=> (half_pair[1] == half_pair[0]));

  // R4
  rz_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt_sel == 2'd1) |=> (half_pair[0] == 1'b0));

  // R5
  rone_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt_sel == 2'd2) |=> (half_pair[0] == 1'b1));

  // R6
  alt_nrz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fmt_sel == 2'd3) |=> (half_pair[1] == half_pair[0]));

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (half_pair == 2'b00 && !pat_start));

  // R7
  first_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> pat_start);

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_out_chk: assert (half_pair == 2'b00 && !pat_start);
    end
  end

endmodule

bind patfmt_top patfmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .fmt_sel   (fmt_sel),
  .half_pair (half_pair),
  .pat_start (pat_start)
);

// File: tb/patfmt_top_tb.sv
module patfmt_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BITS   = 8192;
  localparam int WORD_W     = 32;
  localparam int DEPTH      = MEM_BITS / WORD_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_word = '0;
  logic [31:0] wr_data = '0;
  logic        run = 1'b0;
  logic [13:0] pat_len = 14'd1;
  logic [1:0]  fmt_sel = 2'd0;
  logic        src_prbs = 1'b0;
  logic [1:0]  prbs_sel = 2'd0;
  logic [1:0]  half_pair;
  logic        pat_start;

  int checks = 0;
  int fails  = 0;
  bit model_mem [MEM_BITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  patfmt_top #(.MEM_BITS(MEM_BITS), .WORD_W(WORD_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .wr_data   (wr_data),
    .run       (run),
    .pat_len   (pat_len),
    .fmt_sel   (fmt_sel),
    .src_prbs  (src_prbs),
    .prbs_sel  (prbs_sel),
    .half_pair (half_pair),
    .pat_start (pat_start)
  );

  function automatic logic [1:0] shape(input logic b, input logic [1:0] f);
    case (f)
      2'd1:    return {b, 1'b0};
      2'd2:    return {b, 1'b1};
      default: return {b, b};
    endcase
  endfunction

  function automatic logic [31:0] fill_word(input int w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(input string req, input logic [1:0] ep, input logic es);
    checks++;
    if (half_pair !== ep || pat_start !== es) begin
      fails++;
      $display("FAIL %s: got pair=%b start=%b, expected pair=%b start=%b",
               req, half_pair, pat_start, ep, es);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic write_word(input int w, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_word = 8'(w);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int b = 0; b < WORD_W; b++) model_mem[w*WORD_W + b] = d[b];
  endtask

  task automatic play_mem(input int len_in, input int eff, input logic [1:0] f,
                          input int n, input string req);
    pat_len  = 14'(len_in);
    fmt_sel  = f;
    src_prbs = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, shape(model_mem[i % eff], f), (i % eff) == 0);
    end
    run = 1'b0;
    @(negedge clk);
    chk("R7 idle after stop", 2'b00, 1'b0);
  endtask

  task automatic play_pn(input logic [1:0] sel, input logic [1:0] f, input int n,
                         input string req);
    int ord, tap;
    logic [31:0] st, mask;
    case (sel)
      2'd0:    begin ord = 7;  tap = 6;  end
      2'd1:    begin ord = 15; tap = 14; end
      2'd2:    begin ord = 23; tap = 18; end
      default: begin ord = 31; tap = 28; end
    endcase
    mask     = (32'h1 << ord) - 32'h1;
    src_prbs = 1'b1;
    prbs_sel = sel;
    fmt_sel  = f;
    @(negedge clk);
    run = 1'b1;
    st  = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, shape(st[ord-1], f), (st & mask) == mask);
      st = {st[30:0], st[ord-1] ^ st[tap-1]};
    end
    run      = 1'b0;
    src_prbs = 1'b0;
    @(negedge clk);
    chk("R7 idle after stop", 2'b00, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", 2'b00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle after reset", 2'b00, 1'b0);

    // R1: load the whole store while stopped
    for (int w = 0; w < DEPTH; w++) write_word(w, fill_word(w));

    play_mem(40, 40, 2'd0, 100, "R2 R3 R8 NRZ wrap 40");
    play_mem(33, 33, 2'd1, 70, "R4 RZ wrap 33");
    play_mem(7, 7, 2'd2, 30, "R5 R1 wrap 7");
    play_mem(64, 64, 2'd3, 140, "R6 code3 as NRZ");
    play_mem(1, 1, 2'd2, 6, "R8 length one");
    play_mem(0, 1, 2'd0, 5, "R12 zero length");
    play_mem(16000, 8192, 2'd0, 8195, "R12 oversize length");
    play_mem(8191, 8191, 2'd1, 8194, "R2 long wrap");

    // R1 R2: write and length change mid-run are ignored
    pat_len  = 14'd10;
    fmt_sel  = 2'd0;
    src_prbs = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk("R2 length held while running", shape(model_mem[i % 10], 2'd0), (i % 10) == 0);
      if (i == 4) begin
        wr_en   = 1'b1;
        wr_word = 8'd0;
        wr_data = ~fill_word(0);
        pat_len = 14'd3;
      end
      if (i == 5) wr_en = 1'b0;
    end
    run = 1'b0;
    @(negedge clk);
    chk("R7 idle after stop", 2'b00, 1'b0);
    play_mem(32, 32, 2'd0, 32, "R1 running write dropped");

    // R1: new pattern after stop is taken, bit order check
    write_word(0, 32'h0000_0005);
    play_mem(4, 4, 2'd2, 12, "R1 bit order");

    play_pn(2'd0, 2'd0, 300, "R9 R10 pn7");
    play_pn(2'd1, 2'd1, 200, "R9 pn15");
    play_pn(2'd2, 2'd2, 200, "R9 pn23");
    play_pn(2'd3, 2'd0, 200, "R9 pn31");
    play_mem(5, 5, 2'd0, 10, "R9 back to stored source");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule